// File: doc/BRIEF.md
# Shared Interrupt Line Router

This block steers eight shared, level-sensitive device interrupt requests (lines A through H, indices 0 to 7) and one power-management interrupt level onto the inputs of a 16-input legacy interrupt controller and a 24-input I/O interrupt controller. Each request line has an 8-bit route byte. The byte holds a target IRQ number and a disable flag. A legacy input is the OR of every enabled request routed to it. On the I/O controller side, each request line always owns its own pin, with no sharing.

The power-management level is sampled into a register. A 3-bit select code in a control byte sends it to one of five IRQ numbers. Software writes the route bytes and the control byte through a simple byte-write port. A write to any route byte produces a one-cycle routing-changed pulse, so that downstream logic can refresh cached routes. A combinational query port reports the effective route of any request line.

Top module: `pirq_router`

## Requirements
- R1: After reset every route byte is 0x80 (disabled), the select code is 0 and the sampled power-management level is 0. With all request lines high, every legacy output is therefore low.
- R2: Legacy output k is high when any enabled request line whose IRQ field (route byte bits [4:0]) equals k is high. Several request lines may share one output.
- R3: A request line whose route byte has bit 7 set drives no legacy output.
- R4: An enabled request line whose IRQ field is 16 or more drives no legacy output.
- R5: I/O controller pin 16+n follows request line n at all times, whatever its route byte holds.
- R6: Select code 0, 1 and 2 (control byte bits [2:0]) send the power-management level to IRQ 9, 10 and 11. Codes 4 and 5 send it to IRQ 20 and 21. Codes 3, 6 and 7 send it nowhere. The level is ORed onto the I/O controller pin of the selected IRQ.
- R7: The power-management level reaches a legacy output only when the selected IRQ is below 16, and there it is ORed with the request lines. It is sampled on the clock, so an input change appears one clock edge later.
- R8: Query of line n: with bit 7 set it reports valid with IRQ 16+n. With bit 7 clear and a field below 16, it reports valid with that field. With bit 7 clear and a field of 16 or more, it reports invalid with IRQ 0.
- R9: Byte addresses 0 to 3 hold the route bytes of lines A to D, addresses 4 to 7 hold those of lines E to H, and address 8 holds the control byte. A write to addresses 0 to 7 raises the routing-changed output for exactly the following cycle. No other write raises it.
- R10: Writes to addresses 9 to 15 change no routing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Byte write strobe |
| wrAddr | input | 4 | Byte write address |
| wrData | input | 8 | Byte write data |
| pirqLvl | input | 8 | Shared request levels, bit n is line n |
| sciLvl | input | 1 | Power-management interrupt level |
| queryIdx | input | 3 | Request line to query |
| picIrq | output | 16 | Legacy controller inputs |
| apicIrq | output | 24 | I/O controller inputs |
| queryValid | output | 1 | Queried route is usable |
| queryIrq | output | 5 | Queried IRQ number |
| routeChanged | output | 1 | One-cycle pulse after a route byte write |

## Verification
The properties assume that request levels and the power-management level are stable across each rising clock edge. They also assume that the write port is only qualified by wrEn, so any address value may appear. The bench changes every input on the falling edge and samples outputs shortly after. Reserved select codes and unmapped addresses are driven on purpose, since the properties must hold for them as well.

// File: rtl/pirq_route_pkg.sv
package pirq_route_pkg;

  localparam int PIRQ_COUNT  = 8;
  localparam int PIRQ_IDX_W  = $clog2(PIRQ_COUNT);
  localparam int ROUTE_W     = 8;
  localparam int IRQ_FIELD_W = 5;
  localparam int DIS_BIT     = 7;
  localparam int SEL_W       = 3;

  localparam logic [ROUTE_W-1:0] ROUTE_RESET   = 8'h80;
  localparam logic [SEL_W-1:0]   SCI_SEL_RESET = '0;

  // strobes from control to datapath
  typedef struct packed {
    logic                  routeWe;
    logic [PIRQ_IDX_W-1:0] routeIdx;
    logic                  sciWe;
    logic [ROUTE_W-1:0]    data;
  } routeStrobe_t;

  typedef struct packed {
    logic                   ok;
    logic [IRQ_FIELD_W-1:0] irq;
  } sciTarget_t;

  function automatic sciTarget_t sciTarget(input logic [SEL_W-1:0] code);
    sciTarget_t t;
    t.ok  = 1'b0;
    t.irq = '0;
    case (code)
      3'd0, 3'd1, 3'd2: begin
        t.ok  = 1'b1;
        t.irq = 5'd9 + {2'b00, code};
      end
      3'd4, 3'd5: begin
        t.ok  = 1'b1;
        t.irq = 5'd16 + {2'b00, code};
      end
      default: begin
        t.ok  = 1'b0;
        t.irq = '0;
      end
    endcase
    return t;
  endfunction

endpackage

// File: rtl/pirq_route_ctrl.sv
module pirq_route_ctrl
  import pirq_route_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                wrEn,
  input  logic [ADDR_W-1:0]   wrAddr,
  input  logic [ROUTE_W-1:0]  wrData,
  output routeStrobe_t        strobe,
  output logic                routeChanged
);

  localparam logic [ADDR_W-1:0] SCI_ADDR    = ADDR_W'(PIRQ_COUNT);
  localparam logic [ADDR_W-1:0] ROUTE_LIMIT = ADDR_W'(PIRQ_COUNT);

  logic routeHit;

  // both route groups (A-D, E-H) share one contiguous window
  assign routeHit        = wrEn && (wrAddr < ROUTE_LIMIT);
  assign strobe.routeWe  = routeHit;
  assign strobe.routeIdx = wrAddr[PIRQ_IDX_W-1:0];
  assign strobe.sciWe    = wrEn && (wrAddr == SCI_ADDR);
  assign strobe.data     = wrData;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) routeChanged <= 1'b0;
    else       routeChanged <= routeHit;
  end

endmodule

// File: rtl/pirq_route_datapath.sv
module pirq_route_datapath
  import pirq_route_pkg::*;
#(
  parameter int PIC_LINES  = 16,
  parameter int APIC_LINES = 24
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  routeStrobe_t           strobe,
  input  logic [PIRQ_COUNT-1:0]  pirqLvl,
  input  logic                   sciLvl,
  input  logic [PIRQ_IDX_W-1:0]  queryIdx,
  output logic [PIC_LINES-1:0]   picIrq,
  output logic [APIC_LINES-1:0]  apicIrq,
  output logic                   queryValid,
  output logic [IRQ_FIELD_W-1:0] queryIrq
);

  localparam int APIC_BASE = PIC_LINES;

  logic [ROUTE_W-1:0] routeReg [PIRQ_COUNT];
  logic [SEL_W-1:0]   sciSel;
  logic               sciHeld;
  sciTarget_t         sciTgt;
  logic [APIC_LINES-1:0] sciHit;

  // route byte storage, one register per request line
  for (genvar n = 0; n < PIRQ_COUNT; n++) begin : g_route
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) routeReg[n] <= ROUTE_RESET;
      else if (strobe.routeWe && strobe.routeIdx == PIRQ_IDX_W'(n))
        routeReg[n] <= strobe.data;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sciSel  <= SCI_SEL_RESET;
      sciHeld <= 1'b0;
    end else begin
      sciHeld <= sciLvl;
      if (strobe.sciWe) sciSel <= strobe.data[SEL_W-1:0];
    end
  end

  assign sciTgt = sciTarget(sciSel);

  for (genvar k = 0; k < APIC_LINES; k++) begin : g_sci
    assign sciHit[k] = sciHeld && sciTgt.ok && (sciTgt.irq == IRQ_FIELD_W'(k));
  end

  // legacy side: wired-OR of enabled lines whose field matches k
  for (genvar k = 0; k < PIC_LINES; k++) begin : g_pic
    logic [PIRQ_COUNT-1:0] match;
    for (genvar n = 0; n < PIRQ_COUNT; n++) begin : g_m
      assign match[n] = pirqLvl[n] && !routeReg[n][DIS_BIT]
                        && (routeReg[n][IRQ_FIELD_W-1:0] == IRQ_FIELD_W'(k));
    end
    assign picIrq[k] = (|match) || sciHit[k];
  end

  // I/O controller side: dedicated pin per request line
  for (genvar k = 0; k < APIC_LINES; k++) begin : g_apic
    if (k >= APIC_BASE && k < APIC_BASE + PIRQ_COUNT) begin : g_own
      assign apicIrq[k] = pirqLvl[k-APIC_BASE] || sciHit[k];
    end else begin : g_sci_only
      assign apicIrq[k] = sciHit[k];
    end
  end

  // route query
  logic [ROUTE_W-1:0] qByte;
  assign qByte = routeReg[queryIdx];

  always_comb begin
    if (qByte[DIS_BIT]) begin
      queryValid = 1'b1;
      queryIrq   = IRQ_FIELD_W'(APIC_BASE) + IRQ_FIELD_W'(queryIdx);
    end else if (qByte[IRQ_FIELD_W-1:0] < IRQ_FIELD_W'(PIC_LINES)) begin
      queryValid = 1'b1;
      queryIrq   = qByte[IRQ_FIELD_W-1:0];
    end else begin
      queryValid = 1'b0;
      queryIrq   = '0;
    end
  end

endmodule

// File: rtl/pirq_router.sv
module pirq_router
  import pirq_route_pkg::*;
#(
  parameter int ADDR_W     = 4,
  parameter int PIC_LINES  = 16,
  parameter int APIC_LINES = 24
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   wrEn,
  input  logic [ADDR_W-1:0]      wrAddr,
  input  logic [ROUTE_W-1:0]     wrData,
  input  logic [PIRQ_COUNT-1:0]  pirqLvl,
  input  logic                   sciLvl,
  input  logic [PIRQ_IDX_W-1:0]  queryIdx,
  output logic [PIC_LINES-1:0]   picIrq,
  output logic [APIC_LINES-1:0]  apicIrq,
  output logic                   queryValid,
  output logic [IRQ_FIELD_W-1:0] queryIrq,
  output logic                   routeChanged
);

  routeStrobe_t strobe;

  pirq_route_ctrl #(.ADDR_W(ADDR_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .strobe(strobe), .routeChanged(routeChanged)
  );

  pirq_route_datapath #(.PIC_LINES(PIC_LINES), .APIC_LINES(APIC_LINES)) dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .pirqLvl(pirqLvl),
    .sciLvl(sciLvl), .queryIdx(queryIdx), .picIrq(picIrq),
    .apicIrq(apicIrq), .queryValid(queryValid), .queryIrq(queryIrq)
  );

endmodule

// File: rtl/pirq_route_checker.sv
module pirq_route_checker
  import pirq_route_pkg::*;
(
  input logic                   clk,
  input logic                   rstN,
  input logic                   wrEn,
  input logic [3:0]             wrAddr,
  input logic [PIRQ_COUNT-1:0]  pirqLvl,
  input logic [15:0]            picIrq,
  input logic [23:0]            apicIrq,
  input logic                   queryValid,
  input logic [IRQ_FIELD_W-1:0] queryIrq,
  input logic                   routeChanged
);

  p_note_after_write_r9: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrAddr < 4'd8) |=> routeChanged);

  p_no_spurious_note_r9: assert property (@(posedge clk) disable iff (!rstN)
    !(wrEn && wrAddr < 4'd8) |=> !routeChanged);

  // R5: dedicated pins carry their line; only 20/21 may add the SCI
  p_apic_follows_line_r5: assert property (@(posedge clk) disable iff (!rstN)
    ((apicIrq[23:16] & pirqLvl) == pirqLvl) &&
    ((apicIrq[23:16] & ~8'h30) == (pirqLvl & ~8'h30)));

  p_apic_low_targets_r6: assert property (@(posedge clk) disable iff (!rstN)
    ((apicIrq[15:0] & ~16'h0E00) == 16'h0) && $onehot0(apicIrq[15:0]));

  // R3/R7: with no request high only the SCI can light a legacy input
  p_pic_sci_only_r7: assert property (@(posedge clk) disable iff (!rstN)
    (pirqLvl == '0) |-> (picIrq == apicIrq[15:0]));

  p_query_range_r8: assert property (@(posedge clk) disable iff (!rstN)
    queryValid ? (queryIrq < 5'd24) : (queryIrq == 5'd0));

endmodule

bind pirq_router pirq_route_checker chk_i (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .pirqLvl(pirqLvl),
  .picIrq(picIrq), .apicIrq(apicIrq), .queryValid(queryValid),
  .queryIrq(queryIrq), .routeChanged(routeChanged)
);

// File: tb/pirq_router_tb_top.sv
`timescale 1ns/1ps
module pirq_router_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [3:0]  wrAddr = '0;
  logic [7:0]  wrData = '0;
  logic [7:0]  pirqLvl = 8'hFF;
  logic        sciLvl = 1'b0;
  logic [2:0]  queryIdx = '0;
  logic [15:0] picIrq;
  logic [23:0] apicIrq;
  logic        queryValid;
  logic [4:0]  queryIrq;
  logic        routeChanged;

  int total = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  pirq_router dut_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .pirqLvl(pirqLvl), .sciLvl(sciLvl), .queryIdx(queryIdx),
    .picIrq(picIrq), .apicIrq(apicIrq), .queryValid(queryValid),
    .queryIrq(queryIrq), .routeChanged(routeChanged)
  );

  // {request levels, expected legacy outputs} for the fixed route setup
  localparam logic [23:0] VEC [13] = '{
    {8'h00, 16'h0000}, {8'h01, 16'h0020}, {8'h02, 16'h0020},
    {8'h03, 16'h0020}, {8'h04, 16'h0000}, {8'h08, 16'h0000},
    {8'h10, 16'h0008}, {8'h80, 16'h0008}, {8'h90, 16'h0008},
    {8'h20, 16'h8000}, {8'h40, 16'h0001}, {8'hFF, 16'h8029},
    {8'h6C, 16'h8001}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic writeReg(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  // expected SCI target from R6: returns -1 for reserved codes
  function automatic int sciIrqOf(input int code);
    case (code)
      0: return 9;
      1: return 10;
      2: return 11;
      4: return 20;
      5: return 21;
      default: return -1;
    endcase
  endfunction

  initial begin
    #100us;
    total++; bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] routes [8];
    routes = '{8'h05, 8'h05, 8'h85, 8'h14, 8'h03, 8'h0F, 8'h00, 8'h03};

    // R1 reset state, R5 during reset
    repeat (3) @(negedge clk);
    #1;
    check("R1 pic in reset", 32'(picIrq), 32'h0);
    check("R5 apic in reset", 32'(apicIrq), 32'hFF0000);
    rstN = 1'b1;
    queryIdx = 3'd5;
    @(negedge clk); #1;
    check("R1 pic after reset", 32'(picIrq), 32'h0);
    check("R1 no note", 32'(routeChanged), 32'h0);
    check("R1 query disabled line", {26'h0, queryValid, queryIrq}, {26'h0, 1'b1, 5'd21});

    // R9 program routes, each write pulses the note
    pirqLvl = 8'h00;
    for (int i = 0; i < 8; i++) begin
      writeReg(4'(i), routes[i]);
      #1 check("R9 note after route write", 32'(routeChanged), 32'h1);
    end
    @(negedge clk); #1;
    check("R9 note lasts one cycle", 32'(routeChanged), 32'h0);
    writeReg(4'd8, 8'h03);
    #1 check("R9 no note on control write", 32'(routeChanged), 32'h0);

    // R2 R3 R4 R5 table of request patterns
    for (int v = 0; v < 13; v++) begin
      @(negedge clk);
      pirqLvl = VEC[v][23:16];
      #1;
      check("R2/R3/R4 pic vector", 32'(picIrq), 32'(VEC[v][15:0]));
      check("R5 apic vector", 32'(apicIrq), {8'h0, VEC[v][23:16], 16'h0});
    end

    // R10 unmapped addresses
    @(negedge clk); pirqLvl = 8'h01;
    writeReg(4'd12, 8'h00);
    #1 check("R10 no note unmapped", 32'(routeChanged), 32'h0);
    writeReg(4'd9, 8'h00);
    writeReg(4'd15, 8'h8F);
    #1 check("R10 routing unchanged", 32'(picIrq), 32'h0020);

    // R8 queries
    queryIdx = 3'd0; #1;
    check("R8 enabled field", {26'h0, queryValid, queryIrq}, {26'h0, 1'b1, 5'd5});
    queryIdx = 3'd2; #1;
    check("R8 disabled line", {26'h0, queryValid, queryIrq}, {26'h0, 1'b1, 5'd18});
    queryIdx = 3'd3; #1;
    check("R8 field above 15", {26'h0, queryValid, queryIrq}, {26'h0, 1'b0, 5'd0});
    queryIdx = 3'd5; #1;
    check("R8 field 15", {26'h0, queryValid, queryIrq}, {26'h0, 1'b1, 5'd15});

    // R6 R7 every select code with the level held high
    @(negedge clk); pirqLvl = 8'h00; sciLvl = 1'b1;
    for (int c = 0; c < 8; c++) begin
      int t;
      logic [31:0] expPic, expApic;
      writeReg(4'd8, 8'(c));
      t = sciIrqOf(c);
      expApic = (t >= 0) ? (32'h1 << t) : 32'h0;
      expPic  = (t >= 0 && t < 16) ? (32'h1 << t) : 32'h0;
      #1;
      check("R6 sci apic target", 32'(apicIrq), expApic);
      check("R7 sci pic target", 32'(picIrq), expPic);
    end

    // R7 one-edge sampling latency
    writeReg(4'd8, 8'h01);
    sciLvl = 1'b0;
    @(negedge clk); @(negedge clk);
    sciLvl = 1'b1; #1;
    check("R7 level not yet sampled", 32'(picIrq), 32'h0);
    @(negedge clk); #1;
    check("R7 level after edge", 32'(picIrq), 32'h0400);

    // R2 R7 request and SCI share IRQ 10
    writeReg(4'd0, 8'h0A);
    sciLvl = 1'b0; pirqLvl = 8'h01;
    @(negedge clk); #1;
    check("R2 request alone on 10", 32'(picIrq), 32'h0400);
    pirqLvl = 8'h00; sciLvl = 1'b1;
    @(negedge clk); #1;
    check("R7 sci alone on 10", 32'(picIrq), 32'h0400);

    // R1 reset again with routes and SCI active
    rstN = 1'b0; pirqLvl = 8'hFF; queryIdx = 3'd0; #1;
    check("R1 pic cleared by reset", 32'(picIrq), 32'h0);
    check("R1 route byte back to default", {26'h0, queryValid, queryIrq}, {26'h0, 1'b1, 5'd16});
    @(negedge clk); rstN = 1'b1;
    pirqLvl = 8'h00;
    @(negedge clk); #1;
    check("R1 default select is IRQ 9", 32'(picIrq), 32'h0200);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule